// File: doc/BRIEF.md
# Interrupt and Reset Entry Sequencer

This block moves a small 8-bit processor core into its service routines. It holds a set of interrupt request bits that separate sources can raise and drop on their own. Bit 0 is the non-maskable request, bit 1 is a one-shot maskable request, and every higher bit is a level-held maskable request. When the core reports an instruction boundary and the sequencer is idle, the sequencer picks an entry. If it takes one, it pushes the return address and the status byte through a stack write port. It then fetches the two-byte entry address through a read port and hands the core a new program counter, stack pointer and status byte.

The core stalls instruction fetch while `busy` is high. Each entry runs for a fixed number of cycles, and a reset runs a shorter fetch-only sequence. The maskable request is gated by the interrupt-disable flag as it stood at the previous accepted boundary, not by the live status. A halted core, flagged through `jam_set`, accepts no entry until the next reset. Reset acts as power-up: it clears every register before the reset vector fetch.

Top module: `irq_entry_seq`

## Requirements
- R1: On each clock, bit i of `pending` becomes 1 when `req_set[i]` is high. Otherwise it becomes 0 when `req_clr[i]` is high. Otherwise it keeps its value. The result is visible from the next cycle.
- R2: At an idle boundary where `pending` is nonzero, bit 0 (non-maskable) is serviced when set, and a maskable entry is attempted only when bit 0 is clear.
- R3: An entry issues three stack writes on consecutive cycles at addresses 0x0100+S, 0x0100+S-1 and 0x0100+S-2, with S wrapping modulo 256. The data are, in order: PC high byte, PC low byte, and the status byte with bit 4 cleared and bit 5 set. A write and a read never occur in the same cycle.
- R4: After the writes come two vector reads, low address first. Non-maskable entry reads 0xFFFA/0xFFFB, maskable entry reads 0xFFFE/0xFFFF, and reset reads 0xFFFC/0xFFFD. Read data are returned one cycle after each read strobe.
- R5: `load` pulses for one cycle with `pc_out` = {high byte, low byte} and `sp_out` = S-3. `st_out` is the entry status with bit 4 cleared, plus bit 2 (interrupt-disable) set for a maskable entry.
- R6: A maskable entry is taken only if bit 2 is clear in the status recorded at the previous accepted boundary. That record is `st_in` at a boundary with no entry, the status from `st_out` after an entry, and 0x04 after reset.
- R7: A `jam_set` pulse sets `jammed`. While `jammed` is set, no entry is taken, and only reset clears it.
- R8: At every idle boundary that sees a nonzero `pending`, bits 0 and 1 are cleared whether or not an entry is taken. Bits 2 and above are left for their sources to clear.
- R9: `busy` stays high for exactly 7 cycles per entry, ending with the `load` cycle. Boundaries seen while busy are ignored.
- R10: While `rst` is high and on release, `pending` is 0, `jammed` is 0 and `busy` is high. The reset sequence then ends in `load` with `pc_out` from 0xFFFC/0xFFFD, `sp_out` = 0 and `st_out` = 0x04.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-up reset |
| req_set | input | NUM_SRC | Per-source request raise strobes |
| req_clr | input | NUM_SRC | Per-source request drop strobes |
| boundary | input | 1 | Core is between instructions |
| jam_set | input | 1 | Core has halted |
| pc_in | input | 16 | Current program counter |
| sp_in | input | 8 | Current stack pointer |
| st_in | input | 8 | Current status byte |
| rd_data | input | 8 | Read data, one cycle after `rd_en` |
| pending | output | NUM_SRC | Latched request bits |
| busy | output | 1 | Entry or reset sequence in progress |
| jammed | output | 1 | Halted state |
| wr_en | output | 1 | Stack write strobe |
| wr_addr | output | 16 | Stack write address |
| wr_data | output | 8 | Stack write data |
| rd_en | output | 1 | Vector read strobe |
| rd_addr | output | 16 | Vector read address |
| load | output | 1 | New core state valid |
| pc_out | output | 16 | New program counter |
| sp_out | output | 8 | New stack pointer |
| st_out | output | 8 | New status byte |

## Verification
A stale or wrong mask record shows up at the first boundary after an entry. A level request then either re-enters at once or stays blocked one boundary too long, and `busy` rises on the wrong cycle. A mis-stepped stack counter or a wrong entry kind changes `wr_addr`, `wr_data` or `rd_addr` within one to five cycles of the boundary. A lost or kept request bit changes `pending` on the very next cycle. The bench model predicts every port on every clock, so each of these errors is caught on the cycle it first appears.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;

    localparam logic [DATA_W-1:0] FLAG_I = 8'h04;
    localparam logic [DATA_W-1:0] FLAG_B = 8'h10;
    localparam logic [DATA_W-1:0] FLAG_U = 8'h20;
    localparam logic [DATA_W-1:0] STACK_PAGE = 8'h01;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PUSH_HI,
        ST_PUSH_LO,
        ST_PUSH_ST,
        ST_VEC_LO,
        ST_VEC_HI,
        ST_VEC_CAP,
        ST_DONE
    } seq_state_e;

    typedef enum logic [1:0] {
        KIND_RESET,
        KIND_NMI,
        KIND_IRQ
    } entry_kind_e;

    // Low address of the two-byte vector for each entry kind
    function automatic logic [ADDR_W-1:0] vector_base(entry_kind_e k);
        case (k)
            KIND_NMI: return 16'hFFFA;
            KIND_IRQ: return 16'hFFFE;
            default:  return 16'hFFFC;
        endcase
    endfunction

    // Status byte as written to the stack
    function automatic logic [DATA_W-1:0] stacked_status(logic [DATA_W-1:0] s);
        return (s & ~FLAG_B) | FLAG_U;
    endfunction

    // Status byte handed back to the core after entry
    function automatic logic [DATA_W-1:0] entry_status(logic [DATA_W-1:0] s, entry_kind_e k);
        return (s & ~FLAG_B) | ((k == KIND_IRQ) ? FLAG_I : '0);
    endfunction

endpackage

// File: rtl/irq_req_bank.sv
module irq_req_bank #(
    parameter int NUM_SRC = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] req_set,
    input  logic [NUM_SRC-1:0] req_clr,
    input  logic [NUM_SRC-1:0] consume,
    output logic [NUM_SRC-1:0] pending
);
    logic [NUM_SRC-1:0] pend_q;

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        always_ff @(posedge clk) begin
            if (rst)
                pend_q[i] <= 1'b0;
            else if (req_set[i])
                pend_q[i] <= 1'b1;
            else if (req_clr[i] || consume[i])
                pend_q[i] <= 1'b0;
        end
    end

    assign pending = pend_q;
endmodule

// File: rtl/irq_entry_arbiter.sv
module irq_entry_arbiter #(
    parameter int NUM_SRC = 4
) (
    input  logic [NUM_SRC-1:0] pending,
    input  logic               boundary,
    input  logic               idle,
    input  logic               prev_i,
    input  logic               jammed,
    output logic               take,
    output logic               take_nmi,
    output logic [NUM_SRC-1:0] consume
);
    localparam int ONE_SHOT_LAST = 1;

    logic any_req;
    logic nmi_req;
    logic irq_req;
    logic decide;

    assign any_req  = |pending;
    assign nmi_req  = pending[0];
    assign irq_req  = |pending[NUM_SRC-1:1];
    assign decide   = boundary && idle && any_req;
    assign take_nmi = nmi_req;
    assign take     = decide && !jammed && (nmi_req || (irq_req && !prev_i));

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_cons
        if (i <= ONE_SHOT_LAST) begin : g_drop
            assign consume[i] = decide;
        end else begin : g_keep
            assign consume[i] = 1'b0;
        end
    end
endmodule

// File: rtl/irq_entry_fsm.sv
module irq_entry_fsm
    import irq_entry_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              boundary,
    input  logic              take,
    input  logic              take_nmi,
    input  logic              jam_set,
    input  logic [ADDR_W-1:0] pc_in,
    input  logic [DATA_W-1:0] sp_in,
    input  logic [DATA_W-1:0] st_in,
    input  logic [DATA_W-1:0] rd_data,
    output logic              idle,
    output logic              prev_i,
    output logic              jammed,
    output logic              busy,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              load,
    output logic [ADDR_W-1:0] pc_out,
    output logic [DATA_W-1:0] sp_out,
    output logic [DATA_W-1:0] st_out
);
    seq_state_e        state;
    entry_kind_e       kind;
    entry_kind_e       next_kind;
    logic [ADDR_W-1:0] pc_q;
    logic [DATA_W-1:0] sp_q;
    logic [DATA_W-1:0] st_q;
    logic [DATA_W-1:0] vec_lo;
    logic [DATA_W-1:0] prev_st;
    logic              jam_q;
    logic [ADDR_W-1:0] pc_o;
    logic [DATA_W-1:0] sp_o;
    logic [DATA_W-1:0] st_o;

    assign next_kind = take_nmi ? KIND_NMI : KIND_IRQ;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_VEC_LO;
            kind    <= KIND_RESET;
            pc_q    <= '0;
            sp_q    <= '0;
            st_q    <= FLAG_I;
            vec_lo  <= '0;
            prev_st <= FLAG_I;
            jam_q   <= 1'b0;
            pc_o    <= '0;
            sp_o    <= '0;
            st_o    <= '0;
        end else begin
            if (jam_set)
                jam_q <= 1'b1;
            case (state)
                ST_IDLE: begin
                    if (boundary) begin
                        if (take) begin
                            state   <= ST_PUSH_HI;
                            kind    <= next_kind;
                            pc_q    <= pc_in;
                            sp_q    <= sp_in;
                            st_q    <= st_in;
                            prev_st <= entry_status(st_in, next_kind);
                        end else begin
                            prev_st <= st_in;
                        end
                    end
                end
                ST_PUSH_HI: begin
                    sp_q  <= sp_q - 8'd1;
                    state <= ST_PUSH_LO;
                end
                ST_PUSH_LO: begin
                    sp_q  <= sp_q - 8'd1;
                    state <= ST_PUSH_ST;
                end
                ST_PUSH_ST: begin
                    sp_q  <= sp_q - 8'd1;
                    state <= ST_VEC_LO;
                end
                ST_VEC_LO: state <= ST_VEC_HI;
                ST_VEC_HI: begin
                    vec_lo <= rd_data;
                    state  <= ST_VEC_CAP;
                end
                ST_VEC_CAP: begin
                    pc_o  <= {rd_data, vec_lo};
                    sp_o  <= sp_q;
                    st_o  <= entry_status(st_q, kind);
                    state <= ST_DONE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        wr_en   = 1'b0;
        wr_data = '0;
        case (state)
            ST_PUSH_HI: begin wr_en = 1'b1; wr_data = pc_q[ADDR_W-1:DATA_W]; end
            ST_PUSH_LO: begin wr_en = 1'b1; wr_data = pc_q[DATA_W-1:0]; end
            ST_PUSH_ST: begin wr_en = 1'b1; wr_data = stacked_status(st_q); end
            default: ;
        endcase
    end

    assign wr_addr = {STACK_PAGE, sp_q};
    assign rd_en   = (state == ST_VEC_LO) || (state == ST_VEC_HI);
    assign rd_addr = vector_base(kind) | {15'd0, state == ST_VEC_HI};
    assign idle    = (state == ST_IDLE);
    assign busy    = !idle;
    assign load    = (state == ST_DONE);
    assign prev_i  = |(prev_st & FLAG_I);
    assign jammed  = jam_q;
    assign pc_out  = pc_o;
    assign sp_out  = sp_o;
    assign st_out  = st_o;
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
    import irq_entry_pkg::*;
#(
    parameter int NUM_SRC = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] req_set,
    input  logic [NUM_SRC-1:0] req_clr,
    input  logic               boundary,
    input  logic               jam_set,
    input  logic [15:0]        pc_in,
    input  logic [7:0]         sp_in,
    input  logic [7:0]         st_in,
    input  logic [7:0]         rd_data,
    output logic [NUM_SRC-1:0] pending,
    output logic               busy,
    output logic               jammed,
    output logic               wr_en,
    output logic [15:0]        wr_addr,
    output logic [7:0]         wr_data,
    output logic               rd_en,
    output logic [15:0]        rd_addr,
    output logic               load,
    output logic [15:0]        pc_out,
    output logic [7:0]         sp_out,
    output logic [7:0]         st_out
);
    logic               idle;
    logic               prev_i;
    logic               take;
    logic               take_nmi;
    logic [NUM_SRC-1:0] consume;

    irq_req_bank #(.NUM_SRC(NUM_SRC)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .req_set (req_set),
        .req_clr (req_clr),
        .consume (consume),
        .pending (pending)
    );

    irq_entry_arbiter #(.NUM_SRC(NUM_SRC)) u_arb (
        .pending  (pending),
        .boundary (boundary),
        .idle     (idle),
        .prev_i   (prev_i),
        .jammed   (jammed),
        .take     (take),
        .take_nmi (take_nmi),
        .consume  (consume)
    );

    irq_entry_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .boundary (boundary),
        .take     (take),
        .take_nmi (take_nmi),
        .jam_set  (jam_set),
        .pc_in    (pc_in),
        .sp_in    (sp_in),
        .st_in    (st_in),
        .rd_data  (rd_data),
        .idle     (idle),
        .prev_i   (prev_i),
        .jammed   (jammed),
        .busy     (busy),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_en    (rd_en),
        .rd_addr  (rd_addr),
        .load     (load),
        .pc_out   (pc_out),
        .sp_out   (sp_out),
        .st_out   (st_out)
    );
endmodule

// File: rtl/irq_entry_chk.sv
module irq_entry_chk #(
    parameter int NUM_SRC = 4
) (
    input logic               clk,
    input logic               rst,
    input logic [NUM_SRC-1:0] req_set,
    input logic [NUM_SRC-1:0] req_clr,
    input logic               boundary,
    input logic [NUM_SRC-1:0] pending,
    input logic               busy,
    input logic               jammed,
    input logic               wr_en,
    input logic [15:0]        wr_addr,
    input logic               rd_en,
    input logic [15:0]        rd_addr,
    input logic               load
);
    localparam int LVL = NUM_SRC - 1;

    assert_push_page_R3: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (wr_addr[15:8] == 8'h01));

    assert_no_overlap_R3: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && rd_en));

    assert_entry_starts_push_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> wr_en);

    assert_vector_region_R4: assert property (@(posedge clk) disable iff (rst)
        rd_en |-> (rd_addr[15:3] == 13'h1FFF));

    assert_jam_blocks_R7: assert property (@(posedge clk) disable iff (rst)
        (jammed && boundary && !busy) |=> !busy);

    assert_nmi_consumed_R8: assert property (@(posedge clk) disable iff (rst)
        (boundary && !busy && pending[0] && !req_set[0]) |=> !pending[0]);

    assert_level_kept_R8: assert property (@(posedge clk) disable iff (rst)
        (boundary && !busy && pending[LVL] && !req_clr[LVL]) |=> pending[LVL]);

    assert_load_ends_R9: assert property (@(posedge clk) disable iff (rst)
        load |=> !busy);

    assert_load_while_busy_R9: assert property (@(posedge clk) disable iff (rst)
        load |-> busy);
endmodule

bind irq_entry_seq irq_entry_chk #(.NUM_SRC(NUM_SRC)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .req_set  (req_set),
    .req_clr  (req_clr),
    .boundary (boundary),
    .pending  (pending),
    .busy     (busy),
    .jammed   (jammed),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .rd_en    (rd_en),
    .rd_addr  (rd_addr),
    .load     (load)
);

// File: tb/irq_entry_seq_tb.sv
`timescale 1ns/1ps
module irq_entry_seq_tb;
    localparam int NS = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NS-1:0] req_set = '0, req_clr = '0;
    logic          boundary = 1'b0, jam_set = 1'b0;
    logic [15:0]   pc_in = 16'h0000;
    logic [7:0]    sp_in = 8'hFF, st_in = 8'h00, rd_data = 8'h00;
    logic [NS-1:0] pending;
    logic          busy, jammed, wr_en, rd_en, load;
    logic [15:0]   wr_addr, rd_addr, pc_out;
    logic [7:0]    wr_data, sp_out, st_out;

    int tests = 0, fails = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    irq_entry_seq #(.NUM_SRC(NS)) u_dut (
        .clk(clk), .rst(rst), .req_set(req_set), .req_clr(req_clr),
        .boundary(boundary), .jam_set(jam_set), .pc_in(pc_in), .sp_in(sp_in),
        .st_in(st_in), .rd_data(rd_data), .pending(pending), .busy(busy),
        .jammed(jammed), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .load(load), .pc_out(pc_out),
        .sp_out(sp_out), .st_out(st_out)
    );

    function automatic int vec_mem(int a);
        case (a)
            'hFFFA: return 'h34;
            'hFFFB: return 'h12;
            'hFFFE: return 'h78;
            'hFFFF: return 'h56;
            'hFFFC: return 'hBC;
            'hFFFD: return 'h9A;
            default: return 'hEE;
        endcase
    endfunction

    always @(posedge clk) rd_data <= rd_en ? 8'(vec_mem(int'(rd_addr))) : 8'h00;

    // Reference model: per-cycle expected port activity held in a queue
    typedef struct {
        bit wr, rd, ld;
        int wa, wd, ra, pc, sp, st;
    } step_t;

    step_t q[$];
    int    mpend = 0;
    bit    mjam = 0;
    int    mprev = 'h04;

    function automatic step_t blank();
        step_t s;
        s.wr = 0; s.rd = 0; s.ld = 0;
        s.wa = 0; s.wd = 0; s.ra = 0; s.pc = 0; s.sp = 0; s.st = 0;
        return s;
    endfunction

    task automatic add_fetch(int base, int sp_new, int st_new);
        step_t s;
        s = blank(); s.rd = 1; s.ra = base;     q.push_back(s);
        s = blank(); s.rd = 1; s.ra = base + 1; q.push_back(s);
        s = blank();                            q.push_back(s);
        s = blank(); s.ld = 1;
        s.pc = vec_mem(base + 1) * 256 + vec_mem(base);
        s.sp = sp_new; s.st = st_new;           q.push_back(s);
    endtask

    task automatic add_entry(bit nmi, int pc, int sp, int st);
        step_t s;
        int newst;
        s = blank(); s.wr = 1; s.wa = 'h100 + sp;              s.wd = pc / 256; q.push_back(s);
        s = blank(); s.wr = 1; s.wa = 'h100 + ((sp - 1) & 255); s.wd = pc % 256; q.push_back(s);
        s = blank(); s.wr = 1; s.wa = 'h100 + ((sp - 2) & 255);
        s.wd = (st & ~'h10) | 'h20;                             q.push_back(s);
        newst = (st & ~'h10) | (nmi ? 0 : 'h04);
        add_fetch(nmi ? 'hFFFA : 'hFFFE, (sp - 3) & 255, newst);
        mprev = newst;
    endtask

    always @(posedge clk) begin
        if (rst) begin
            q.delete();
            mpend = 0; mjam = 0; mprev = 'h04;
            add_fetch('hFFFC, 0, 'h04);
        end else begin
            bit idle;
            int cons;
            idle = (q.size() == 0);
            cons = 0;
            if (!idle) void'(q.pop_front());
            if (idle && boundary) begin
                if (mpend != 0) begin
                    cons = 3;
                    if (!mjam && ((mpend & 1) != 0 || ((mpend & 'hE) != 0 && (mprev & 4) == 0)))
                        add_entry((mpend & 1) != 0, int'(pc_in), int'(sp_in), int'(st_in));
                    else
                        mprev = int'(st_in);
                end else begin
                    mprev = int'(st_in);
                end
            end
            if (jam_set) mjam = 1;
            mpend = ((mpend & ~cons & ~int'(req_clr)) | int'(req_set)) & 'hF;
        end
    end

    task automatic chk(string tag, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare();
        step_t h;
        h = (q.size() != 0) ? q[0] : blank();
        chk("R1 pending", int'(pending), mpend);
        chk("R7 jammed", int'(jammed), int'(mjam));
        chk("R9 busy", int'(busy), int'(q.size() != 0));
        chk("R3 wr_en", int'(wr_en), int'(h.wr));
        if (h.wr) begin
            chk("R3 wr_addr", int'(wr_addr), h.wa);
            chk("R3 wr_data", int'(wr_data), h.wd);
        end
        chk("R4 rd_en", int'(rd_en), int'(h.rd));
        if (h.rd) chk("R4 rd_addr", int'(rd_addr), h.ra);
        chk("R5 load", int'(load), int'(h.ld));
        if (h.ld) begin
            chk("R5 pc_out", int'(pc_out), h.pc);
            chk("R5 sp_out", int'(sp_out), h.sp);
            chk("R5 st_out", int'(st_out), h.st);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
        compare();
        req_set = '0; req_clr = '0; boundary = 1'b0; jam_set = 1'b0;
    endtask

    task automatic ticks(int n, bit hold_boundary);
        for (int i = 0; i < n; i++) begin
            boundary = hold_boundary;
            tick();
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        tick(); tick();
        chk("R10 pending at reset", int'(pending), 0);
        chk("R10 jammed at reset", int'(jammed), 0);
        chk("R10 busy at reset", int'(busy), 1);
        rst = 1'b0;
        ticks(5, 1'b0);
    endtask

    initial begin
        #(4 * 200000);
        if (!finished) begin
            fails++; tests++;
            $display("FAIL watchdog: actual running expected done");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        do_reset();

        // R6: boundary with nothing pending records live status (I clear)
        pc_in = 16'hC123; sp_in = 8'hFD; st_in = 8'h00;
        boundary = 1; tick();
        // R1/R2: level maskable request on bit 2, taken
        req_set = 4'b0100; tick();
        boundary = 1; tick();
        ticks(7, 1'b1);                 // R9: boundaries ignored while busy
        chk("R9 idle after entry", int'(busy), 0);
        // R6: recorded I set blocks entry although live I is clear
        boundary = 1; tick();
        chk("R6 masked by recorded status", int'(busy), 0);
        chk("R8 level bit kept", int'(pending[2]), 1);
        boundary = 1; tick();
        chk("R6 entry after record cleared", int'(busy), 1);
        ticks(7, 1'b0);
        req_clr = 4'b0100; tick();

        // R2: NMI wins over level IRQ, stack wrap at S=1
        req_set = 4'b1001; tick();
        pc_in = 16'h8001; sp_in = 8'h01; st_in = 8'h14;
        boundary = 1; tick();
        ticks(3, 1'b0);
        chk("R2 NMI vector chosen", int'(rd_addr), 'hFFFA);
        ticks(4, 1'b0);
        chk("R8 level bit 3 kept after NMI", int'(pending[3]), 1);
        req_clr = 4'b1000; tick();

        // R8: one-shot bit dropped though masked
        st_in = 8'h04; boundary = 1; tick();
        req_set = 4'b0010; tick();
        boundary = 1; tick();
        chk("R8 one-shot dropped", int'(pending[1]), 0);
        chk("R6 masked one-shot no entry", int'(busy), 0);

        // R1: set wins over clear in the same cycle
        req_set = 4'b0100; req_clr = 4'b0100; tick();
        chk("R1 set over clear", int'(pending[2]), 1);
        req_clr = 4'b0100; tick();

        // R7: halted core refuses NMI
        jam_set = 1; tick();
        req_set = 4'b0001; tick();
        boundary = 1; tick();
        chk("R7 no entry while jammed", int'(busy), 0);
        ticks(2, 1'b0);

        // R10: reset clears halt, then NMI taken again
        do_reset();
        chk("R10 jam cleared", int'(jammed), 0);
        pc_in = 16'h4455; sp_in = 8'h80; st_in = 8'hFF;
        req_set = 4'b0001; tick();
        boundary = 1; tick();
        ticks(8, 1'b0);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule